// File: doc/BRIEF.md
# Process-Tagged Translation Entry Flush Scanner

This block removes the translations that belong to one address-space tag from a pair of translation lookaside buffers (one for instruction fetch, one for data) without touching anything else. A flush command carries a process tag. The block then reads every entry of both buffers through a read port into the entry storage, which lies outside the block. For each entry that is live, is not shared across processes, and carries the requested tag, it raises an invalidate strobe together with the page address of that entry. A downstream page cache uses the strobe to drop its copy of the page.

The default geometry is two buffers, each with four ways of sixteen rows, so a flush visits 128 entries. One entry is read per cycle. The storage answers one cycle after a read. The scan has a request/busy/done handshake. While a scan runs, a new request has no effect.

Top module: `tlb_pid_flush`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `inv_vld_o` are all low.
- R2: A request sampled while idle raises `busy_o` in the next cycle. From that cycle on, `rd_en_o` is high for exactly 128 consecutive cycles, and `rd_addr_o` runs 0, 1, 2 … 127. Address = buffer×64 + way×16 + row, so the buffer is the outermost loop and the row is the innermost.
- R3: An entry produces a strobe only if all of these hold: its low word bit 3 (live) is 1, its low word bit 4 (shared) is 0, and its high word bits [7:0] equal the flush tag.
- R4: The strobe address equals the entry's high word bits [31:13], placed at bits [31:13], with bits [12:0] zero.
- R5: Only bits [7:0] of `flush_pid_i` take part. Upper bits have no effect on which entries are strobed.
- R6: The strobe for the entry read at address e appears exactly two cycles after the cycle in which `rd_addr_o` = e with `rd_en_o` high.
- R7: Each matching entry gives exactly one strobe, one cycle long. Entries that do not match give none, so the strobe count of a flush equals the number of matching entries.
- R8: `busy_o` stays high until the last entry has been checked. `done_o` is high for exactly one cycle, two cycles after the read of address 127, and `busy_o` is low in that same cycle.
- R9: A request that arrives while `busy_o` is high is ignored: the scan is not restarted and its tag is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_req_i | input | 1 | Flush request, sampled while idle |
| flush_pid_i | input | 32 | Flush tag; only bits [7:0] are used |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when the scan ends |
| rd_en_o | output | 1 | Entry read request |
| rd_addr_o | output | 7 | Entry address {buffer, way, row} |
| rd_hi_i | input | 32 | Entry high word, one cycle after the read |
| rd_lo_i | input | 32 | Entry low word, one cycle after the read |
| inv_vld_o | output | 1 | Invalidate strobe |
| inv_page_o | output | 32 | Page address of the invalidated entry |

## Verification
The results follow a request on a fixed schedule:
- `busy_o` and the first read are due one cycle after the request is sampled.
- Each strobe is due two cycles after the read of its entry.
- `done_o` is due two cycles after the read of address 127.

The bench samples at the falling edge. It keeps a two-deep history of the read address it saw, and from that history it predicts the strobe, the page, busy and done for every cycle of the scan. It then compares all four in that same cycle. Storage contents are computed arithmetically for several fill patterns, and a second request is injected in the middle of one scan.

// File: rtl/tlb_flush_pkg.sv
package tlb_flush_pkg;
    // Entry field positions decoded by this block
    localparam int unsigned LIVE_BIT   = 3;
    localparam int unsigned SHARED_BIT = 4;
    localparam int unsigned PAGE_SHIFT = 13;
    localparam int unsigned TAG_W      = 8;
    localparam int unsigned WORD_W     = 32;
endpackage

// File: rtl/flush_entry_match.sv
module flush_entry_match #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned TAG_W      = 8,
    parameter int unsigned LIVE_BIT   = 3,
    parameter int unsigned SHARED_BIT = 4,
    parameter int unsigned PAGE_SHIFT = 13
) (
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] page_o
);
    logic tag_eq;

    always_comb begin
        tag_eq = (hi_i[TAG_W-1:0] == tag_i);
        hit_o  = lo_i[LIVE_BIT] && !lo_i[SHARED_BIT] && tag_eq;
        page_o = {hi_i[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/flush_scan_seq.sv
module flush_scan_seq #(
    parameter int unsigned N_ENT = 128,
    parameter int unsigned ENT_W = $clog2(N_ENT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             issue_o,
    output logic [ENT_W-1:0] ptr_o,
    output logic             chk_vld_o,
    output logic             done_o
);
    localparam logic [ENT_W-1:0] LAST = ENT_W'(N_ENT - 1);

    typedef struct packed {
        logic             busy;
        logic             issue;
        logic [ENT_W-1:0] ptr;
        logic             chk_vld;
        logic             chk_last;
        logic             done;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d          = seq_q;
        seq_d.done     = 1'b0;
        seq_d.chk_vld  = seq_q.issue;
        seq_d.chk_last = seq_q.issue && (seq_q.ptr == LAST);
        accept_o       = !seq_q.busy && start_i;
        if (accept_o) begin
            seq_d.busy  = 1'b1;
            seq_d.issue = 1'b1;
            seq_d.ptr   = '0;
        end
        if (seq_q.issue) begin
            if (seq_q.ptr == LAST) seq_d.issue = 1'b0;
            else                   seq_d.ptr   = seq_q.ptr + 1'b1;
        end
        if (seq_q.chk_vld && seq_q.chk_last) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign busy_o    = seq_q.busy;
    assign issue_o   = seq_q.issue;
    assign ptr_o     = seq_q.ptr;
    assign chk_vld_o = seq_q.chk_vld;
    assign done_o    = seq_q.done;

    p_read_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_o |-> busy_o);
    p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_o && ptr_o != LAST) |=> (issue_o && ptr_o == $past(ptr_o) + 1'b1));
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(busy_o) && !busy_o));
    p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_o && ptr_o != '0) |=> (ptr_o != '0 || !issue_o));
endmodule

// File: rtl/tlb_pid_flush.sv
module tlb_pid_flush
    import tlb_flush_pkg::*;
#(
    parameter int unsigned N_BUF = 2,
    parameter int unsigned N_WAY = 4,
    parameter int unsigned N_ROW = 16,
    localparam int unsigned N_ENT = N_BUF * N_WAY * N_ROW,
    localparam int unsigned ENT_W = $clog2(N_ENT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_req_i,
    input  logic [31:0]       flush_pid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [ENT_W-1:0]  rd_addr_o,
    input  logic [WORD_W-1:0] rd_hi_i,
    input  logic [WORD_W-1:0] rd_lo_i,
    output logic              inv_vld_o,
    output logic [WORD_W-1:0] inv_page_o
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              vld;
        logic [WORD_W-1:0] page;
    } rep_t;

    rep_t rep_q, rep_d;

    logic              accept, chk_vld, hit;
    logic [WORD_W-1:0] page;

    flush_scan_seq #(.N_ENT(N_ENT), .ENT_W(ENT_W)) i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (flush_req_i),
        .accept_o  (accept),
        .busy_o    (busy_o),
        .issue_o   (rd_en_o),
        .ptr_o     (rd_addr_o),
        .chk_vld_o (chk_vld),
        .done_o    (done_o)
    );

    flush_entry_match #(
        .WORD_W(WORD_W), .TAG_W(TAG_W), .LIVE_BIT(LIVE_BIT),
        .SHARED_BIT(SHARED_BIT), .PAGE_SHIFT(PAGE_SHIFT)
    ) i_match (
        .hi_i   (rd_hi_i),
        .lo_i   (rd_lo_i),
        .tag_i  (rep_q.tag),
        .hit_o  (hit),
        .page_o (page)
    );

    always_comb begin
        rep_d      = rep_q;
        rep_d.vld  = chk_vld && hit;
        rep_d.page = (chk_vld && hit) ? page : '0;
        if (accept) rep_d.tag = flush_pid_i[TAG_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rep_q <= '0;
        else         rep_q <= rep_d;
    end

    assign inv_vld_o  = rep_q.vld;
    assign inv_page_o = rep_q.page;

    p_strobe_rule_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_vld_o |-> ($past(rd_lo_i[LIVE_BIT]) && !$past(rd_lo_i[SHARED_BIT])
                       && $past(rd_hi_i[TAG_W-1:0]) == $past(rep_q.tag)));
    p_page_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_vld_o |-> (inv_page_o[WORD_W-1:PAGE_SHIFT] == $past(rd_hi_i[WORD_W-1:PAGE_SHIFT])));
    p_strobe_in_scan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_vld_o |-> (busy_o || done_o));
    p_tag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(rep_q.tag));
endmodule

// File: tb/test_tlb_pid_flush.sv
module test_tlb_pid_flush;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] pid_in = '0;
    logic        busy, done, rd_en, inv_vld;
    logic [6:0]  rd_addr;
    logic [31:0] rd_hi = '0, rd_lo = '0, inv_page;
    logic [31:0] mem_hi [N];
    logic [31:0] mem_lo [N];
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    tlb_pid_flush i_tlb_pid_flush (
        .clk_i(clk), .rst_ni(rst_n), .flush_req_i(req), .flush_pid_i(pid_in),
        .busy_o(busy), .done_o(done), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
        .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .inv_vld_o(inv_vld), .inv_page_o(inv_page)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_hi <= mem_hi[rd_addr];
            rd_lo <= mem_lo[rd_addr];
        end
    end

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(input int e, input logic [7:0] p);
        return mem_lo[e][3] && !mem_lo[e][4] && (mem_hi[e][7:0] == p);
    endfunction

    task automatic fill(input int mode);
        for (int e = 0; e < N; e++) begin
            case (mode)
                0: begin
                    mem_hi[e] = {19'(e * 613 + 77), 5'(e), 8'(e % 6)};
                    mem_lo[e] = {19'(e * 3), 8'h5A, (e % 5 == 0), (e % 4 != 3), 3'(e)};
                end
                1: begin
                    mem_hi[e] = {19'(e * 4099 + 1), 5'h1F, 8'hAB};
                    mem_lo[e] = {19'(e), 8'h00, 1'b0, 1'b1, 3'b111};
                end
                2: begin
                    mem_hi[e] = {19'(e + 9), 5'h00, 8'hAB};
                    mem_lo[e] = {19'(e), 8'h00, 1'b1, 1'b1, 3'b000};
                end
                default: begin
                    mem_hi[e] = {19'(e + 3), 5'h00, 8'hAB};
                    mem_lo[e] = {19'(e), 8'hFF, 1'b0, 1'b0, 3'b111};
                end
            endcase
        end
    endtask

    task automatic run_flush(input logic [31:0] pid, input bit poke_mid);
        logic [7:0] p8;
        int  nexp, reads, strobes, cyc, a1, a2;
        bit  en1, en2, fin, e_done, e_str;
        p8 = pid[7:0];
        nexp = 0;
        for (int e = 0; e < N; e++) if (exp_hit(e, p8)) nexp++;
        reads = 0; strobes = 0; cyc = 0; a1 = 0; a2 = 0;
        en1 = 0; en2 = 0; fin = 0;
        @(negedge clk);
        req = 1'b1; pid_in = pid;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R2", "busy after request", busy, 1);
        while (!fin && cyc < 400) begin
            e_done = en2 && (a2 == N - 1);
            e_str  = en2 && exp_hit(a2, p8);
            chk(done == e_done, "R8", "done", done, e_done);
            chk(busy == !e_done, "R8", "busy", busy, !e_done);
            chk(inv_vld == e_str, "R6", "strobe timing", inv_vld, e_str);
            if (e_str)
                chk(inv_page == {mem_hi[a2][31:13], 13'b0}, "R4", "page", inv_page,
                    {mem_hi[a2][31:13], 13'b0});
            if (rd_en) begin
                chk(int'(rd_addr) == reads, "R2", "read order", rd_addr, reads);
                reads++;
            end
            if (inv_vld) strobes++;
            en2 = en1; a2 = a1;
            en1 = rd_en; a1 = int'(rd_addr);
            if (e_done) fin = 1;
            // R9: second request mid-scan with another tag
            if (poke_mid && cyc == 40) begin req = 1'b1; pid_in = ~pid; end
            else req = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req = 1'b0;
        chk(fin, "R8", "done seen", fin, 1);
        chk(done == 1'b0, "R8", "done one cycle", done, 0);
        chk(busy == 1'b0 && rd_en == 1'b0, "R9", "idle after scan", {busy, rd_en}, 0);
        chk(reads == N, "R2", "read count", reads, N);
        chk(strobes == nexp, "R7", "strobe count", strobes, nexp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, rd_en, inv_vld} == 4'b0, "R1", "reset outputs",
            {busy, done, rd_en, inv_vld}, 0);
        run_flush(32'h0000_0002, 1'b0);               // R3 mixed
        run_flush(32'h1234_5603, 1'b0);               // R5 upper bits ignored
        run_flush(32'hFFFF_FF00, 1'b0);               // R5
        run_flush(32'h0000_0005, 1'b1);               // R9 mid-scan request
        fill(1); run_flush(32'h0000_00AB, 1'b0);      // R7 every entry matches
        run_flush(32'h0000_00AA, 1'b0);               // R3 tag mismatch
        fill(2); run_flush(32'h0000_00AB, 1'b0);      // R3 shared entries skipped
        fill(3); run_flush(32'h0000_00AB, 1'b1);      // R3 dead entries skipped
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule